// File: doc/BRIEF.md
# Virtually Tagged Direct-Mapped Cache with Process Tags

This block is a small data cache that sits between a processor and memory. It uses the virtual address both to pick a line and to compare against the stored tag. A hit therefore completes without address translation. Each line records which process filled it. A lookup hits only when the line is valid, its virtual tag matches, and the stored process tag matches the requester's. Because of this, a context switch does not have to empty the cache.

On a read miss the block sends the virtual address to an external translation port and waits a variable time for the physical address. It then reads the word from memory at that physical address and installs it in the line. Every line also keeps the physical word address it was filled from. A write hit updates the line and writes through to that stored address without new translation. A write miss is translated and written to memory without allocating a line. A one-cycle flush input invalidates every line. When the block is built with process-tag checking turned off, it detects a change of requesting process and invalidates every line by itself.

The CPU holds its request and its operands steady until `cpu_ready_o` is high, which it is for exactly one cycle per request. A read hit returns data in the cycle the request is presented.

Top module: `vtag_cache`

## Requirements
- R1: A read request that hits raises `cpu_ready_o` in the same cycle with the line's data on `cpu_rdata_o`, and asserts neither `xl_req_o` nor `mem_req_o` for it.
- R2: On a miss, `xl_req_o` is held with `xl_va_o` equal to the request's virtual address until `xl_valid_i`. The memory access that follows uses `mem_pa_o` equal to the returned `xl_pa_i`.
- R3: A lookup hits only when the indexed line is valid, its stored virtual tag equals the request's tag, and (with checking on) its stored process tag equals `cpu_pid_i`.
- R4: A request with the same virtual address from a different process misses and refills the line under the new process tag, so a later request from the first process misses again.
- R5: With process-tag checking off (`PID_CHECK`=0), a request whose process tag differs from the previous request's invalidates every line and misses. Later requests from the new process hit normally once their lines are refilled.
- R6: A cycle with `flush_i` high leaves every line invalid on the next cycle, so the first access to each line afterwards misses. All lines are also invalid after reset.
- R7: The cache is direct-mapped. The line index is `va[5:2]` and the tag is `va[31:6]`. Two addresses with the same index and different tags evict each other.
- R8: A write hit updates the line's data and writes the word through to memory at the line's stored physical address, with `mem_we_o`=1 and no translation. A later read hits and returns the new word.
- R9: A write miss is translated, then written to memory at the physical address with `mem_we_o`=1. It allocates no line, so the line that was resident stays resident.
- R10: A read miss writes the `mem_rdata_i` word into the line. `cpu_ready_o` rises in the cycle after `mem_valid_i`, carrying that word, and the next read of the address hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all lines |
| cpu_req_i | input | 1 | CPU request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_va_i | input | 32 | Virtual byte address (word aligned) |
| cpu_pid_i | input | 4 | Process tag of the requester |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ready_o | output | 1 | Request complete (one cycle) |
| cpu_rdata_o | output | 32 | Read data, valid with ready on reads |
| xl_req_o | output | 1 | Translation request |
| xl_va_o | output | 32 | Virtual address to translate |
| xl_valid_i | input | 1 | Translation result valid |
| xl_pa_i | input | 32 | Physical address |
| mem_req_o | output | 1 | Memory request, held until valid |
| mem_we_o | output | 1 | Memory write enable |
| mem_pa_o | output | 32 | Physical address to memory |
| mem_wdata_o | output | 32 | Memory write data |
| mem_valid_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The hardest situation to reach is a false hit: a line whose virtual tag matches exactly but belongs to another process, or that survives a process change in the unchecked build. The bench fills all sixteen lines under one process tag. It then replays the identical addresses under a second tag and checks that every one goes to translation. On a second instance built without tag checking, it fills lines under one process and then walks them all under a new one, so lines that were never touched at the switch must also miss. Translation and memory latencies vary with address bits, so each fill path is exercised with several wait lengths.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XLATE = 2'd1,
        ST_MEM   = 2'd2,
        ST_RESP  = 2'd3
    } vtc_state_e;
endpackage

// File: rtl/vtc_tag_store.sv
module vtc_tag_store #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int PID_W = 4,
    parameter int PWA_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [IDX_W-1:0] lk_idx_i,
    input  logic [TAG_W-1:0] lk_tag_i,
    input  logic [PID_W-1:0] lk_pid_i,
    output logic             lk_valid_o,
    output logic             lk_tag_eq_o,
    output logic             lk_pid_eq_o,
    output logic [PWA_W-1:0] lk_pwa_o,
    input  logic             fill_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic [PID_W-1:0] fill_pid_i,
    input  logic [PWA_W-1:0] fill_pwa_i
);
    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tag;
        logic [LINES-1:0][PID_W-1:0] pid;
        logic [LINES-1:0][PWA_W-1:0] pwa;
    } tags_t;

    tags_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fill_i) begin
            s_d.valid[fill_idx_i] = 1'b1;
            s_d.tag[fill_idx_i]   = fill_tag_i;
            s_d.pid[fill_idx_i]   = fill_pid_i;
            s_d.pwa[fill_idx_i]   = fill_pwa_i;
        end
        if (flush_i) begin
            s_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // single comparator pair, selected by the index
    assign lk_valid_o  = s_q.valid[lk_idx_i];
    assign lk_tag_eq_o = (s_q.tag[lk_idx_i] == lk_tag_i);
    assign lk_pid_eq_o = (s_q.pid[lk_idx_i] == lk_pid_i);
    assign lk_pwa_o    = s_q.pwa[lk_idx_i];

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (s_q.valid == '0)); // R6
endmodule

// File: rtl/vtc_data_store.sv
module vtc_data_store #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);
    logic [LINES-1:0][DATA_W-1:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        if (wr_en_i) words_d[wr_idx_i] = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) words_q <= '0;
        else        words_q <= words_d;
    end

    assign rd_data_o = words_q[rd_idx_i];
endmodule

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
    import vtc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PID_W     = 4,
    parameter int OFF_W     = 2,
    parameter int PID_CHECK = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req_i,
    input  logic                  cpu_we_i,
    input  logic [ADDR_W-1:0]     cpu_va_i,
    input  logic [PID_W-1:0]      cpu_pid_i,
    input  logic [DATA_W-1:0]     cpu_wdata_i,
    output logic                  cpu_ready_o,
    output logic [DATA_W-1:0]     cpu_rdata_o,
    input  logic                  lk_valid_i,
    input  logic                  lk_tag_eq_i,
    input  logic                  lk_pid_eq_i,
    input  logic [ADDR_W-OFF_W-1:0] lk_pwa_i,
    input  logic [DATA_W-1:0]     rd_data_i,
    output logic                  fill_o,
    output logic [ADDR_W-OFF_W-1:0] fill_pwa_o,
    output logic                  wr_en_o,
    output logic [DATA_W-1:0]     wr_data_o,
    output logic                  auto_flush_o,
    output logic                  xl_req_o,
    output logic [ADDR_W-1:0]     xl_va_o,
    input  logic                  xl_valid_i,
    input  logic [ADDR_W-1:0]     xl_pa_i,
    output logic                  mem_req_o,
    output logic                  mem_we_o,
    output logic [ADDR_W-1:0]     mem_pa_o,
    output logic [DATA_W-1:0]     mem_wdata_o,
    input  logic                  mem_valid_i,
    input  logic [DATA_W-1:0]     mem_rdata_i
);
    localparam logic PID_IGNORE = (PID_CHECK == 0);

    typedef struct packed {
        vtc_state_e        st;
        logic              fill;
        logic [ADDR_W-1:0] pa;
        logic [DATA_W-1:0] resp;
        logic [PID_W-1:0]  last_pid;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  pid_switch;
    logic  hit;

    // with tag checking off, a change of process empties the cache
    assign pid_switch = PID_IGNORE && (cpu_pid_i != r_q.last_pid);
    assign hit = lk_valid_i && lk_tag_eq_i && (lk_pid_eq_i || PID_IGNORE) && !pid_switch;

    always_comb begin
        r_d          = r_q;
        cpu_ready_o  = 1'b0;
        cpu_rdata_o  = '0;
        fill_o       = 1'b0;
        wr_en_o      = 1'b0;
        wr_data_o    = cpu_wdata_i;
        auto_flush_o = 1'b0;
        xl_req_o     = 1'b0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cpu_req_i) begin
                    r_d.last_pid = cpu_pid_i;
                    auto_flush_o = pid_switch;
                    if (hit) begin
                        if (!cpu_we_i) begin
                            cpu_ready_o = 1'b1;
                            cpu_rdata_o = rd_data_i;
                        end else begin
                            wr_en_o  = 1'b1;
                            r_d.pa   = {lk_pwa_i, {OFF_W{1'b0}}};
                            r_d.fill = 1'b0;
                            r_d.st   = ST_MEM;
                        end
                    end else begin
                        r_d.fill = !cpu_we_i;
                        r_d.st   = ST_XLATE;
                    end
                end
            end
            ST_XLATE: begin
                xl_req_o = 1'b1;
                if (xl_valid_i) begin
                    r_d.pa = xl_pa_i;
                    r_d.st = ST_MEM;
                end
            end
            ST_MEM: begin
                mem_req_o = 1'b1;
                mem_we_o  = !r_q.fill;
                if (mem_valid_i) begin
                    if (r_q.fill) begin
                        fill_o    = 1'b1;
                        wr_en_o   = 1'b1;
                        wr_data_o = mem_rdata_i;
                    end
                    r_d.resp = mem_rdata_i;
                    r_d.st   = ST_RESP;
                end
            end
            default: begin
                cpu_ready_o = 1'b1;
                cpu_rdata_o = r_q.resp;
                r_d.st      = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, fill: 1'b0, pa: '0, resp: '0, last_pid: '0};
        else        r_q <= r_d;
    end

    assign xl_va_o     = cpu_va_i;
    assign mem_pa_o    = r_q.pa;
    assign mem_wdata_o = cpu_wdata_i;
    assign fill_pwa_o  = r_q.pa[ADDR_W-1:OFF_W];

    AST_HIT_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && cpu_req_i && hit) |=> !xl_req_o); // R1
    AST_XLATE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xl_req_o) |-> $past(cpu_req_i && !hit)); // R2
    AST_MEM_ADDR_FROM_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MEM && $past(r_q.st == ST_XLATE)) |-> (mem_pa_o == $past(xl_pa_i))); // R2
    AST_WRMISS_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o |-> !cpu_we_i); // R9
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready_o && r_q.st == ST_RESP) |=> (r_q.st == ST_IDLE)); // R10
endmodule

// File: rtl/vtag_cache.sv
module vtag_cache #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PID_W     = 4,
    parameter int LINES     = 16,
    parameter int PID_CHECK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_va_i,
    input  logic [PID_W-1:0]  cpu_pid_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ready_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              xl_req_o,
    output logic [ADDR_W-1:0] xl_va_o,
    input  logic              xl_valid_i,
    input  logic [ADDR_W-1:0] xl_pa_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_pa_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_valid_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int PWA_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              lk_valid, lk_tag_eq, lk_pid_eq;
    logic [PWA_W-1:0]  lk_pwa, fill_pwa;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              fill, wr_en, auto_flush;

    assign idx = cpu_va_i[OFF_W +: IDX_W];
    assign tag = cpu_va_i[ADDR_W-1 -: TAG_W];

    vtc_tag_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PID_W(PID_W), .PWA_W(PWA_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i | auto_flush),
        .lk_idx_i   (idx),
        .lk_tag_i   (tag),
        .lk_pid_i   (cpu_pid_i),
        .lk_valid_o (lk_valid),
        .lk_tag_eq_o(lk_tag_eq),
        .lk_pid_eq_o(lk_pid_eq),
        .lk_pwa_o   (lk_pwa),
        .fill_i     (fill),
        .fill_idx_i (idx),
        .fill_tag_i (tag),
        .fill_pid_i (cpu_pid_i),
        .fill_pwa_i (fill_pwa)
    );

    vtc_data_store #(
        .LINES(LINES), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_i (idx),
        .rd_data_o(rd_data),
        .wr_en_i  (wr_en),
        .wr_idx_i (idx),
        .wr_data_i(wr_data)
    );

    vtc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PID_W(PID_W), .OFF_W(OFF_W), .PID_CHECK(PID_CHECK)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req_i   (cpu_req_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_va_i    (cpu_va_i),
        .cpu_pid_i   (cpu_pid_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_ready_o (cpu_ready_o),
        .cpu_rdata_o (cpu_rdata_o),
        .lk_valid_i  (lk_valid),
        .lk_tag_eq_i (lk_tag_eq),
        .lk_pid_eq_i (lk_pid_eq),
        .lk_pwa_i    (lk_pwa),
        .rd_data_i   (rd_data),
        .fill_o      (fill),
        .fill_pwa_o  (fill_pwa),
        .wr_en_o     (wr_en),
        .wr_data_o   (wr_data),
        .auto_flush_o(auto_flush),
        .xl_req_o    (xl_req_o),
        .xl_va_o     (xl_va_o),
        .xl_valid_i  (xl_valid_i),
        .xl_pa_i     (xl_pa_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_pa_o    (mem_pa_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_valid_i (mem_valid_i),
        .mem_rdata_i (mem_rdata_i)
    );
endmodule

// File: tb/vtag_cache_tb.sv
`timescale 1ns/1ps

module vtc_bus_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xl_req,
    input  logic [31:0] xl_va,
    output logic        xl_valid,
    output logic [31:0] xl_pa,
    input  logic        mem_req,
    input  logic        mem_we,
    input  logic [31:0] mem_pa,
    input  logic [31:0] mem_wdata,
    output logic        mem_valid,
    output logic [31:0] mem_rdata
);
    logic [31:0] mem [256];
    logic [1:0]  xcnt, mcnt;

    assign xl_pa     = xl_va ^ 32'h8000_0000;
    assign mem_rdata = mem[mem_pa[9:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            xcnt <= '0; mcnt <= '0; xl_valid <= 1'b0; mem_valid <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] <= 32'h5EED_0000 ^ (i * 32'h0001_0101);
        end else begin
            if (xl_req && !xl_valid) begin
                if (xcnt >= xl_va[3:2]) begin xl_valid <= 1'b1; xcnt <= '0; end
                else xcnt <= xcnt + 2'd1;
            end else xl_valid <= 1'b0;
            if (mem_req && !mem_valid) begin
                if (mcnt >= mem_pa[5:4]) begin
                    mem_valid <= 1'b1; mcnt <= '0;
                    if (mem_we) mem[mem_pa[9:2]] <= mem_wdata;
                end else mcnt <= mcnt + 2'd1;
            end else mem_valid <= 1'b0;
        end
    end
endmodule

module vtag_cache_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic req0 = 1'b0, req1 = 1'b0, we = 1'b0;
    logic [31:0] va = '0, wdata = '0;
    logic [3:0]  pid = '0;

    logic        rdy [2];
    logic [31:0] rdat [2];
    logic        xreq [2], xval [2], mreq [2], mwe [2], mval [2];
    logic [31:0] xva [2], xpa [2], mpa [2], mwd [2], mrd [2];

    int n_cmp = 0, n_bad = 0;
    int r_cyc;
    logic r_xl, r_mem, r_mwe, r_to;
    logic [31:0] r_pa, r_wd, r_rd;

    always #4 clk = ~clk;

    vtag_cache #(.PID_CHECK(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .cpu_req_i(req0), .cpu_we_i(we),
        .cpu_va_i(va), .cpu_pid_i(pid), .cpu_wdata_i(wdata), .cpu_ready_o(rdy[0]),
        .cpu_rdata_o(rdat[0]), .xl_req_o(xreq[0]), .xl_va_o(xva[0]), .xl_valid_i(xval[0]),
        .xl_pa_i(xpa[0]), .mem_req_o(mreq[0]), .mem_we_o(mwe[0]), .mem_pa_o(mpa[0]),
        .mem_wdata_o(mwd[0]), .mem_valid_i(mval[0]), .mem_rdata_i(mrd[0]));

    vtag_cache #(.PID_CHECK(0)) u_dut_np (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .cpu_req_i(req1), .cpu_we_i(we),
        .cpu_va_i(va), .cpu_pid_i(pid), .cpu_wdata_i(wdata), .cpu_ready_o(rdy[1]),
        .cpu_rdata_o(rdat[1]), .xl_req_o(xreq[1]), .xl_va_o(xva[1]), .xl_valid_i(xval[1]),
        .xl_pa_i(xpa[1]), .mem_req_o(mreq[1]), .mem_we_o(mwe[1]), .mem_pa_o(mpa[1]),
        .mem_wdata_o(mwd[1]), .mem_valid_i(mval[1]), .mem_rdata_i(mrd[1]));

    vtc_bus_model u_bus0 (.clk(clk), .rst_n(rst_n), .xl_req(xreq[0]), .xl_va(xva[0]),
        .xl_valid(xval[0]), .xl_pa(xpa[0]), .mem_req(mreq[0]), .mem_we(mwe[0]),
        .mem_pa(mpa[0]), .mem_wdata(mwd[0]), .mem_valid(mval[0]), .mem_rdata(mrd[0]));
    vtc_bus_model u_bus1 (.clk(clk), .rst_n(rst_n), .xl_req(xreq[1]), .xl_va(xva[1]),
        .xl_valid(xval[1]), .xl_pa(xpa[1]), .mem_req(mreq[1]), .mem_we(mwe[1]),
        .mem_pa(mpa[1]), .mem_wdata(mwd[1]), .mem_valid(mval[1]), .mem_rdata(mrd[1]));

    function automatic logic [31:0] init_word(input logic [7:0] slot);
        return 32'h5EED_0000 ^ (32'(slot) * 32'h0001_0101);
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input int sel, input logic w, input logic [31:0] a,
                          input logic [3:0] p, input logic [31:0] d);
        @(negedge clk);
        we = w; va = a; pid = p; wdata = d;
        if (sel == 0) req0 = 1'b1; else req1 = 1'b1;
        r_cyc = 0; r_xl = 0; r_mem = 0; r_mwe = 0; r_to = 0; r_pa = '0; r_wd = '0;
        forever begin
            #1;
            if (xreq[sel]) r_xl = 1'b1;
            if (mreq[sel]) begin r_mem = 1'b1; r_pa = mpa[sel]; r_mwe = mwe[sel]; r_wd = mwd[sel]; end
            if (rdy[sel]) begin r_rd = rdat[sel]; break; end
            if (r_cyc > 60) begin r_to = 1'b1; break; end
            @(negedge clk);
            r_cyc++;
        end
        @(posedge clk);
        #1 req0 = 1'b0; req1 = 1'b0;
        chk(!r_to, "R2", "request completion", 32'(r_cyc), 32'd0);
    endtask

    function automatic logic [31:0] va_of(input logic [3:0] hi, input logic [3:0] slot, input int i);
        return (32'(hi) << 24) | (32'(slot) << 6) | (32'(i) << 2);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(rdy[0] == 0 && xreq[0] == 0 && mreq[0] == 0, "R6", "idle after reset", {29'd0, rdy[0], xreq[0], mreq[0]}, 32'd0);
        rst_n = 1'b1;

        // fills under process 3, then hits (R10, R2, R1, R6)
        for (int i = 0; i < 16; i++) begin
            access(0, 0, va_of(4'h1, 4'd1, i), 4'd3, '0);
            chk(r_xl && r_cyc > 0, "R6", "first access misses", 32'(r_cyc), 32'd1);
            chk(r_pa == (va_of(4'h1, 4'd1, i) ^ 32'h8000_0000), "R2", "fill address", r_pa, va_of(4'h1, 4'd1, i) ^ 32'h8000_0000);
            chk(r_rd == init_word({4'd1, 4'(i)}), "R10", "miss data", r_rd, init_word({4'd1, 4'(i)}));
            access(0, 0, va_of(4'h1, 4'd1, i), 4'd3, '0);
            chk(r_cyc == 0 && !r_xl && !r_mem, "R1", "same-cycle hit", 32'(r_cyc), 32'd0);
            chk(r_rd == init_word({4'd1, 4'(i)}), "R1", "hit data", r_rd, init_word({4'd1, 4'(i)}));
        end

        // same address from other process misses (R3, R4)
        for (int i = 0; i < 16; i++) begin
            access(0, 0, va_of(4'h1, 4'd1, i), 4'd5, '0);
            chk(r_xl, "R3", "foreign process no false hit", {31'd0, r_xl}, 32'd1);
            access(0, 0, va_of(4'h1, 4'd1, i), 4'd3, '0);
            chk(r_xl, "R4", "original process misses after refill", {31'd0, r_xl}, 32'd1);
            chk(r_rd == init_word({4'd1, 4'(i)}), "R4", "refill data", r_rd, init_word({4'd1, 4'(i)}));
        end

        // write hits (R8)
        for (int i = 0; i < 16; i++) begin
            access(0, 1, va_of(4'h1, 4'd1, i), 4'd3, 32'hD00D_0000 | 32'(i));
            chk(!r_xl && r_mem && r_mwe, "R8", "write hit writes through untranslated", {29'd0, r_xl, r_mem, r_mwe}, 32'd3);
            chk(r_pa == (va_of(4'h1, 4'd1, i) ^ 32'h8000_0000), "R8", "write-through address", r_pa, va_of(4'h1, 4'd1, i) ^ 32'h8000_0000);
            access(0, 0, va_of(4'h1, 4'd1, i), 4'd3, '0);
            chk(r_cyc == 0 && r_rd == (32'hD00D_0000 | 32'(i)), "R8", "read after write hit", r_rd, 32'hD00D_0000 | 32'(i));
        end

        // conflicts on the same index (R7)
        for (int i = 0; i < 16; i++) begin
            access(0, 0, va_of(4'h2, 4'd2, i), 4'd3, '0);
            chk(r_xl && r_rd == init_word({4'd2, 4'(i)}), "R7", "conflicting tag misses", r_rd, init_word({4'd2, 4'(i)}));
            access(0, 0, va_of(4'h1, 4'd1, i), 4'd3, '0);
            chk(r_xl, "R7", "evicted line misses", {31'd0, r_xl}, 32'd1);
            chk(r_rd == (32'hD00D_0000 | 32'(i)), "R8", "written word reached memory", r_rd, 32'hD00D_0000 | 32'(i));
        end

        // write misses do not allocate (R9)
        for (int i = 0; i < 16; i++) begin
            access(0, 1, va_of(4'h3, 4'd3, i), 4'd3, 32'hBEEF_0000 | 32'(i));
            chk(r_xl && r_mwe && r_pa == (va_of(4'h3, 4'd3, i) ^ 32'h8000_0000), "R9", "write miss translated", r_pa, va_of(4'h3, 4'd3, i) ^ 32'h8000_0000);
            chk(r_wd == (32'hBEEF_0000 | 32'(i)), "R9", "write miss data", r_wd, 32'hBEEF_0000 | 32'(i));
            access(0, 0, va_of(4'h1, 4'd1, i), 4'd3, '0);
            chk(r_cyc == 0 && !r_xl, "R9", "resident line kept", 32'(r_cyc), 32'd0);
            access(0, 0, va_of(4'h3, 4'd3, i), 4'd3, '0);
            chk(r_xl && r_rd == (32'hBEEF_0000 | 32'(i)), "R9", "no allocation on write miss", r_rd, 32'hBEEF_0000 | 32'(i));
        end

        // flush (R6)
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < 16; i++) begin
            access(0, 0, va_of(4'h3, 4'd3, i), 4'd3, '0);
            chk(r_xl, "R6", "miss after flush", {31'd0, r_xl}, 32'd1);
        end

        // no tag checking: process change empties the cache (R5)
        for (int i = 0; i < 16; i++) begin
            access(1, 0, va_of(4'h4, 4'd4, i), 4'd1, '0);
            access(1, 0, va_of(4'h4, 4'd4, i), 4'd1, '0);
            chk(r_cyc == 0 && r_rd == init_word({4'd4, 4'(i)}), "R5", "hit within process", r_rd, init_word({4'd4, 4'(i)}));
        end
        for (int i = 0; i < 16; i++) begin
            access(1, 0, va_of(4'h4, 4'd4, i), 4'd2, '0);
            chk(r_xl, "R5", "miss after process switch", {31'd0, r_xl}, 32'd1);
        end
        for (int i = 0; i < 16; i++) begin
            access(1, 0, va_of(4'h4, 4'd4, i), 4'd2, '0);
            chk(r_cyc == 0 && !r_xl, "R5", "hit after refill by new process", 32'(r_cyc), 32'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule